// File: doc/BRIEF.md
# Spline-Modulated Sinusoid Channel

This block produces one channel's sinusoid sample every clock cycle. The sample is the product of a cubic amplitude curve and the cosine of a quadratic phase curve, plus a bias value that arrives at a separate input. The two curves advance once per cycle by forward differencing, so only additions are needed. The cosine and the amplitude product come together out of a pipelined CORDIC rotator. That rotator scales its result by its natural gain of about 1.64676, and nothing in the block removes that gain. The final sum is clipped to the signed 16-bit range.

Software writes the coefficients as 16-bit words into a bank of holding registers. Writing a word has no effect on the waveform. A trigger pulse copies the whole bank into the running curves in a single cycle. A phase-clear input is sampled together with the trigger. It selects one of two behaviours: the phase restarts from the new constant term, or it carries on from its running value and uses the new rate terms from then on.

Top module: `sdds_channel`

## Requirements
- R1: While `rst` is high, `sample_o` is 0 on the cycle after each reset edge. After reset is released, and with no trigger yet, the output equals the delayed bias.
- R2: Words written without a trigger leave the running curves unchanged. The output keeps following the previously committed waveform.
- R3: Word map, low half first wherever a value spans words. Word 0 is amplitude constant A0 (16 bits). Words 1–2 are slope A1 (32 bits). Words 3–5 are A2 (48 bits). Words 6–8 are A3 (48 bits). On a trigger the 48-bit amplitude accumulator loads {A0, 32 zero bits}.
- R4: In every non-trigger cycle the amplitude curve steps as acc += d1, d1 += d2, d2 += d3. All four are 48 bits and wrap. At commit, d1 = {A1, 16 zero bits}, d2 = A2 and d3 = A3.
- R5: Word 9 is phase constant P0. Words 10–11 are rate P1. Words 12–13 are P2. In every non-trigger cycle the 32-bit phase steps as ph += rate, rate += P2, and both wrap. At commit, rate = P1. A full 2^32 wrap of the phase is one turn.
- R6: On a trigger with `phase_clr_i` = 1, the phase loads {P0, 16 zero bits}. With `phase_clr_i` = 0 it advances once more by the old rate. In both cases the rate and P2 take their new values.
- R7: `sample_o` equals bias + 1.64676 · A · cos(2π · P / 65536) within ±6 LSB, 18 cycles after the cycle whose state it reflects. A is the top 16 bits of the amplitude accumulator, signed. P is the top 16 bits of the phase. The bias is the one present in that same cycle.
- R8: Sums above 32767 or below −32768 are clipped to 32767 or −32768 respectively.
- R9: Writes to addresses 14 and 15 change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one spline step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Coefficient word write strobe |
| wr_addr_i | input | 4 | Coefficient word index |
| wr_data_i | input | 16 | Coefficient word value |
| trig_i | input | 1 | Commit pulse for the holding bank |
| phase_clr_i | input | 1 | Restart the phase on this commit |
| bias_i | input | 16 | Signed bias added to the sinusoid |
| sample_o | output | 16 | Signed, clipped channel sample |

## Verification
Several behaviours are checked on every cycle. These are: the zero output after a reset edge, the amplitude constant landing in the accumulator on a commit, the phase restarting from the new constant when clearing is requested, and the bank staying put on writes to unmapped addresses. Only the bench scenarios can show the rest. That covers the accuracy of the rotated cosine over the whole turn, the 18-cycle alignment of the bias with the sinusoid, and the clipping at both rails. It also covers the difference between a cleared and a continued phase, and the fact that uncommitted words never reach the output.

// File: rtl/sdds_pkg.sv
package sdds_pkg;
  localparam int WORD_W    = 16;
  localparam int N_WORDS   = 14;
  localparam int ADDR_W    = 4;
  localparam int AMP_ACC_W = 3 * WORD_W;
  localparam int PH_ACC_W  = 2 * WORD_W;
  localparam int ANGLE_W   = 20;

  // word indices whose positions the spline loader decodes
  localparam int IDX_A0   = 0;
  localparam int IDX_A1   = 1;
  localparam int IDX_A2   = 3;
  localparam int IDX_A3   = 6;
  localparam int IDX_P0   = 9;
  localparam int IDX_P1   = 10;
  localparam int IDX_P2   = 12;

  typedef logic [N_WORDS-1:0][WORD_W-1:0] coef_words_t;

  // arctan(2^-i) in turns, scaled by 2^ANGLE_W
  function automatic logic [ANGLE_W-1:0] atan_turns(input int i);
    case (i)
      0:  return ANGLE_W'(131072);
      1:  return ANGLE_W'(77376);
      2:  return ANGLE_W'(40883);
      3:  return ANGLE_W'(20753);
      4:  return ANGLE_W'(10417);
      5:  return ANGLE_W'(5213);
      6:  return ANGLE_W'(2607);
      7:  return ANGLE_W'(1304);
      8:  return ANGLE_W'(652);
      9:  return ANGLE_W'(326);
      10: return ANGLE_W'(163);
      11: return ANGLE_W'(81);
      12: return ANGLE_W'(41);
      13: return ANGLE_W'(20);
      14: return ANGLE_W'(10);
      15: return ANGLE_W'(5);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sdds_coef_bank.sv
module sdds_coef_bank
  import sdds_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output coef_words_t       words_o
);
  coef_words_t words_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      words_q <= '0;
    end else if (wr_en && (int'(wr_addr) < N_WORDS)) begin
      words_q[wr_addr] <= wr_data;
    end
  end

  assign words_o = words_q;
endmodule

// File: rtl/sdds_spline_engine.sv
module sdds_spline_engine
  import sdds_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     trig,
  input  logic                     phase_clr,
  input  coef_words_t              words,
  output logic signed [WORD_W-1:0] amp_o,
  output logic [WORD_W-1:0]        phase_o
);
  logic [AMP_ACC_W-1:0] amp_q, d1_q, d2_q, d3_q;
  logic [PH_ACC_W-1:0]  ph_q, rate_q, accel_q;

  logic [AMP_ACC_W-1:0] ld_amp, ld_d1, ld_d2, ld_d3;
  logic [PH_ACC_W-1:0]  ld_ph, ld_rate, ld_accel;

  always_comb begin
    ld_amp   = {words[IDX_A0], {(AMP_ACC_W-WORD_W){1'b0}}};
    ld_d1    = {words[IDX_A1+1], words[IDX_A1], {WORD_W{1'b0}}};
    ld_d2    = {words[IDX_A2+2], words[IDX_A2+1], words[IDX_A2]};
    ld_d3    = {words[IDX_A3+2], words[IDX_A3+1], words[IDX_A3]};
    ld_ph    = {words[IDX_P0], {(PH_ACC_W-WORD_W){1'b0}}};
    ld_rate  = {words[IDX_P1+1], words[IDX_P1]};
    ld_accel = {words[IDX_P2+1], words[IDX_P2]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_q   <= '0;
      d1_q    <= '0;
      d2_q    <= '0;
      d3_q    <= '0;
      ph_q    <= '0;
      rate_q  <= '0;
      accel_q <= '0;
    end else if (trig) begin
      amp_q   <= ld_amp;
      d1_q    <= ld_d1;
      d2_q    <= ld_d2;
      d3_q    <= ld_d3;
      ph_q    <= phase_clr ? ld_ph : ph_q + rate_q;
      rate_q  <= ld_rate;
      accel_q <= ld_accel;
    end else begin
      amp_q   <= amp_q + d1_q;
      d1_q    <= d1_q + d2_q;
      d2_q    <= d2_q + d3_q;
      ph_q    <= ph_q + rate_q;
      rate_q  <= rate_q + accel_q;
    end
  end

  assign amp_o   = amp_q[AMP_ACC_W-1 -: WORD_W];
  assign phase_o = ph_q[PH_ACC_W-1 -: WORD_W];
endmodule

// File: rtl/sdds_cordic_rot.sv
module sdds_cordic_rot
  import sdds_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int GUARD  = 4,
  parameter int STAGES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [IN_W-1:0] amp_i,
  input  logic [IN_W-1:0]        phase_i,
  output logic signed [IN_W+1:0] rot_o
);
  localparam int XW = IN_W + 2 + GUARD;

  logic signed [XW-1:0]      x_q [STAGES+1];
  logic signed [XW-1:0]      y_q [STAGES+1];
  logic signed [ANGLE_W-1:0] z_q [STAGES+1];

  // fold the two middle quadrants onto the outer ones by negating x
  logic              fold;
  logic [IN_W-1:0]   ph_fold;
  logic signed [XW-1:0] amp_ext;

  always_comb begin
    fold    = phase_i[IN_W-1] ^ phase_i[IN_W-2];
    ph_fold = phase_i ^ {fold, {(IN_W-1){1'b0}}};
    amp_ext = XW'(amp_i) <<< GUARD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s <= STAGES; s++) begin
        x_q[s] <= '0;
        y_q[s] <= '0;
        z_q[s] <= '0;
      end
    end else begin
      x_q[0] <= fold ? -amp_ext : amp_ext;
      y_q[0] <= '0;
      z_q[0] <= {ph_fold, {(ANGLE_W-IN_W){1'b0}}};
      for (int s = 0; s < STAGES; s++) begin
        if (z_q[s][ANGLE_W-1]) begin
          x_q[s+1] <= x_q[s] + (y_q[s] >>> s);
          y_q[s+1] <= y_q[s] - (x_q[s] >>> s);
          z_q[s+1] <= z_q[s] + $signed(atan_turns(s));
        end else begin
          x_q[s+1] <= x_q[s] - (y_q[s] >>> s);
          y_q[s+1] <= y_q[s] + (x_q[s] >>> s);
          z_q[s+1] <= z_q[s] - $signed(atan_turns(s));
        end
      end
    end
  end

  logic signed [XW-1:0] x_rnd;
  assign x_rnd = x_q[STAGES] + XW'(1 << (GUARD - 1));
  assign rot_o = x_rnd[XW-1:GUARD];
endmodule

// File: rtl/sdds_channel.sv
module sdds_channel
  import sdds_pkg::*;
#(
  parameter int STAGES = 16,
  parameter int GUARD  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [WORD_W-1:0]        wr_data_i,
  input  logic                     trig_i,
  input  logic                     phase_clr_i,
  input  logic signed [WORD_W-1:0] bias_i,
  output logic signed [WORD_W-1:0] sample_o
);
  localparam int BIAS_DLY = STAGES + 1;
  localparam int SUM_W    = WORD_W + 3;
  localparam int MAX_I    = (2 ** (WORD_W - 1)) - 1;
  localparam int MIN_I    = -(2 ** (WORD_W - 1));

  coef_words_t              words;
  logic signed [WORD_W-1:0] amp_cur;
  logic [WORD_W-1:0]        phase_cur;
  logic signed [WORD_W+1:0] rot;

  sdds_coef_bank u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .words_o (words)
  );

  sdds_spline_engine u_spline (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig_i),
    .phase_clr (phase_clr_i),
    .words     (words),
    .amp_o     (amp_cur),
    .phase_o   (phase_cur)
  );

  sdds_cordic_rot #(
    .IN_W   (WORD_W),
    .GUARD  (GUARD),
    .STAGES (STAGES)
  ) u_rot (
    .clk     (clk),
    .rst     (rst),
    .amp_i   (amp_cur),
    .phase_i (phase_cur),
    .rot_o   (rot)
  );

  // bias travels alongside the rotator so both meet in the output register
  logic signed [WORD_W-1:0] bias_pipe [BIAS_DLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < BIAS_DLY; k++) bias_pipe[k] <= '0;
    end else begin
      bias_pipe[0] <= bias_i;
      for (int k = 1; k < BIAS_DLY; k++) bias_pipe[k] <= bias_pipe[k-1];
    end
  end

  logic signed [SUM_W-1:0] sum_w;
  logic signed [WORD_W-1:0] clip_w;

  always_comb begin
    sum_w = SUM_W'(rot) + SUM_W'(bias_pipe[BIAS_DLY-1]);
    if (sum_w > SUM_W'(MAX_I))      clip_w = WORD_W'(MAX_I);
    else if (sum_w < SUM_W'(MIN_I)) clip_w = WORD_W'(MIN_I);
    else                            clip_w = sum_w[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) sample_o <= '0;
    else     sample_o <= clip_w;
  end
endmodule

// File: rtl/sdds_channel_chk.sv
module sdds_channel_chk
  import sdds_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic                     trig_i,
  input logic                     phase_clr_i,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        wr_addr_i,
  input coef_words_t              words,
  input logic signed [WORD_W-1:0] amp_v,
  input logic [WORD_W-1:0]        phase_v,
  input logic signed [WORD_W-1:0] sample_o
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> sample_o == '0);

  // R3
  amp_load_chk: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> amp_v == $signed($past(words[IDX_A0])));

  // R6
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_i && phase_clr_i) |=> phase_v == $past(words[IDX_P0]));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (int'(wr_addr_i) >= N_WORDS)) |=> $stable(words));
endmodule

bind sdds_channel sdds_channel_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .trig_i      (trig_i),
  .phase_clr_i (phase_clr_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .words       (words),
  .amp_v       (amp_cur),
  .phase_v     (phase_cur),
  .sample_o    (sample_o)
);

// File: tb/sdds_channel_bench.sv
module sdds_channel_bench;
  localparam int LAT = 18;
  localparam int TOL = 6;
  localparam real GAIN = 1.6467602581;
  localparam real TWO_PI = 6.283185307179586;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trig = 1'b0;
  logic        phase_clr = 1'b0;
  logic signed [15:0] bias = '0;
  logic signed [15:0] sample;

  always #2 clk = ~clk;

  sdds_channel u_sdds_channel (
    .clk (clk), .rst (rst), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
    .wr_data_i (wr_data), .trig_i (trig), .phase_clr_i (phase_clr),
    .bias_i (bias), .sample_o (sample)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference state built from the requirements
  logic [15:0] sh [14];
  logic [47:0] m_amp, m_d1, m_d2, m_d3;
  logic [31:0] m_ph, m_rate, m_accel;
  int hist [32];

  function automatic int ref_sample(logic [15:0] a, logic [15:0] p, logic [15:0] b);
    real v;
    v = real'($signed(b)) + real'($signed(a)) * GAIN * $cos(TWO_PI * real'(p) / 65536.0);
    if (v > 32767.0) return 32767;
    if (v < -32768.0) return -32768;
    return int'(v);
  endfunction

  always @(posedge clk) begin
    hist[cyc % 32] = rst ? 0 : ref_sample(m_amp[47:32], m_ph[31:16], bias);
    if (rst) begin
      for (int i = 0; i < 14; i++) sh[i] = '0;
      m_amp = '0; m_d1 = '0; m_d2 = '0; m_d3 = '0;
      m_ph = '0; m_rate = '0; m_accel = '0;
    end else begin
      if (trig) begin
        m_amp = {sh[0], 32'h0};
        m_d1 = {sh[2], sh[1], 16'h0};
        m_d2 = {sh[5], sh[4], sh[3]};
        m_d3 = {sh[8], sh[7], sh[6]};
        m_ph = phase_clr ? {sh[9], 16'h0} : m_ph + m_rate;
        m_rate = {sh[11], sh[10]};
        m_accel = {sh[13], sh[12]};
      end else begin
        m_amp = m_amp + m_d1;
        m_d1 = m_d1 + m_d2;
        m_d2 = m_d2 + m_d3;
        m_ph = m_ph + m_rate;
        m_rate = m_rate + m_accel;
      end
      if (wr_en && wr_addr < 4'd14) sh[wr_addr] = wr_data;
    end
    cyc++;
  end

  // streaming comparison against the delayed reference
  always @(negedge clk) begin
    if (!done && cyc >= LAT) begin
      int e, d;
      e = hist[(cyc - LAT) % 32];
      d = int'(sample) - e;
      n_chk++;
      if (d > TOL || d < -TOL) begin
        n_fail++;
        $display("FAIL %s: sample=%0d expected=%0d cycle=%0d", cur_req, sample, e, cyc);
      end
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    trig = 0; wr_en = 1; wr_addr = a[3:0]; wr_data = d;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; trig = 0;
    end
  endtask

  task automatic fire(input logic clr);
    @(negedge clk);
    wr_en = 0; trig = 1; phase_clr = clr;
    @(negedge clk);
    trig = 0; phase_clr = 0;
  endtask

  task automatic load_amp(input logic [15:0] b0, input logic [31:0] b1,
                          input logic [47:0] b2, input logic [47:0] b3);
    wr(0, b0); wr(1, b1[15:0]); wr(2, b1[31:16]);
    wr(3, b2[15:0]); wr(4, b2[31:16]); wr(5, b2[47:32]);
    wr(6, b3[15:0]); wr(7, b3[31:16]); wr(8, b3[47:32]);
  endtask

  task automatic load_ph(input logic [15:0] c0, input logic [31:0] c1, input logic [31:0] c2);
    wr(9, c0); wr(10, c1[15:0]); wr(11, c1[31:16]);
    wr(12, c2[15:0]); wr(13, c2[31:16]);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    // R1: reset state
    cur_req = "R1";
    repeat (4) @(negedge clk);
    check_eq("R1", int'(sample), 0);
    rst = 0;
    run(25);
    check_eq("R1", int'(sample), 0);

    // R3/R4: cubic amplitude at zero phase
    cur_req = "R4";
    load_amp(16'd2000, 32'h0001_8000, 48'h0000_0100_0000, 48'h0000_0000_4000);
    load_ph(16'h0, 32'h0, 32'h0);
    fire(1);
    run(60);
    cur_req = "R3";
    load_amp(16'hE000, 32'h0, 48'h0, 48'h0);
    fire(1);
    run(30);
    check_eq("R3", int'(sample), ref_sample(16'hE000, 16'h0, 16'h0));

    // R5: chirped phase, fixed amplitude, constant bias
    cur_req = "R5";
    bias = 16'sd1000;
    load_amp(16'd12000, 32'h0, 48'h0, 48'h0);
    load_ph(16'h1000, 32'h0123_4567, 32'h0001_2345);
    fire(1);
    run(150);

    // R2: staged words must not reach the output
    cur_req = "R2";
    load_amp(16'd500, 32'h7FFF_0000, 48'h0, 48'h0);
    load_ph(16'h4000, 32'h4000_0000, 32'h0);
    run(40);

    // R6: continue versus restart
    cur_req = "R6";
    load_ph(16'h2000, 32'h0200_0000, 32'h0);
    fire(0);
    run(40);
    fire(1);
    run(40);

    // R8: both rails
    cur_req = "R8";
    load_amp(16'd32767, 32'h0, 48'h0, 48'h0);
    load_ph(16'h0, 32'h0, 32'h0);
    fire(1);
    bias = 16'sd32767;
    run(30);
    check_eq("R8", int'(sample), 32767);
    load_ph(16'h8000, 32'h0, 32'h0);
    fire(1);
    bias = -16'sd32768;
    run(30);
    check_eq("R8", int'(sample), -32768);

    // R9: unmapped addresses
    cur_req = "R9";
    bias = 16'sd0;
    load_amp(16'd9000, 32'h0, 48'h0, 48'h0);
    load_ph(16'h0, 32'h0080_0000, 32'h0);
    wr(14, 16'hFFFF);
    wr(15, 16'hA5A5);
    fire(1);
    run(40);

    // R7: constrained random coefficients, bias and commits
    cur_req = "R7";
    for (int r = 0; r < 25; r++) begin
      for (int w = 0; w < 14; w++) wr(w, 16'($urandom));
      if (r % 3 == 0) wr(14 + (r % 2), 16'($urandom));
      fire(1'($urandom));
      for (int k = 0; k < 70; k++) begin
        @(negedge clk);
        wr_en = 0; trig = 0;
        bias = 16'($urandom) >>> ($urandom % 4);
      end
    end
    bias = 0;
    run(LAT + 2);
    report();
  end
endmodule